// File: doc/BRIEF.md
# Register Busy-Flag Scoreboard

This block keeps one busy bit for each architectural floating-point register and decides, each cycle, whether the instruction sitting in the issue stage may leave. A bit is raised when an instruction that writes that register issues. It drops when that instruction's result is written back. An instruction is held if any source it actually reads is still awaiting a result, which is a read-after-write hazard. It is also held if its own destination is already owed a result by an older instruction. This second check is a deliberately coarse guard against write-after-write reordering: it stalls whatever the relative latencies of the two writers are. Write-after-read needs no check, because every instruction still in flight read its operands before any younger one issued.

Write-back is modelled as happening in the first half of the cycle. A flag cleared by a write-back in a cycle is therefore already invisible to the stall decision in that same cycle. The `stall` output acts as back-pressure on the issue stage. The issue stage may pulse `iss_fire` only while `stall` is low. A pulse given while `stall` is high is discarded and changes no flag.

Top module: `fp_busy_scoreboard`

## Requirements
- R1: Reset clears every busy flag, so right after reset no source or destination index causes `stall`.
- R2: `stall` is high whenever a source whose use bit is 1 names a register whose flag is set and is not being cleared by write-back in the same cycle.
- R3: A source whose use bit is 0 never contributes to `stall`, whatever the state of the register it names.
- R4: When `dst_wr` is 1 and the destination's flag is set (and not cleared this cycle), `stall` is high; when `dst_wr` is 0 the destination index is not checked.
- R5: An accepted issue (`iss_fire`=1, `stall`=0, `dst_wr`=1) sets the destination's flag from the next clock edge onward.
- R6: A write-back (`wb_valid`=1) clears the flag of `wb_idx` at the clock edge, and the clear is already seen by `stall` in the same cycle.
- R7: If an accepted issue sets the same register that a write-back clears in the same cycle, the flag ends up set.
- R8: `iss_fire` while `stall` is high, or with `dst_wr`=0, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src1_idx | input | 5 | First source register index |
| src1_use | input | 1 | First source is read by the instruction |
| src2_idx | input | 5 | Second source register index |
| src2_use | input | 1 | Second source is read by the instruction |
| dst_idx | input | 5 | Destination register index |
| dst_wr | input | 1 | Instruction writes a destination register |
| iss_fire | input | 1 | Issue stage releases the instruction this cycle |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_idx | input | 5 | Register written back |
| stall | output | 1 | Hold the issue-stage instruction this cycle |

## Verification
The bench targets a same-cycle write-back on a register that a waiting source or destination names. A design that clears only at the edge would stall one cycle too long there. It drives an issue and a write-back on one register in the same cycle, where a clear-wins priority would leave a live producer untracked and let a later reader through early. It also pulses fire while stalled and fires instructions with no destination, which a design that forgets to gate the set would use to mark registers busy spuriously. Unused sources and an unwritten destination that name busy registers catch a design that ignores the use masks.

// File: rtl/fp_sb_pkg.sv
package fp_sb_pkg;
  localparam int unsigned SB_NUM_REGS = 32;
  localparam int unsigned SB_IDX_W    = $clog2(SB_NUM_REGS);

  typedef logic [SB_IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] busy_q,
  output logic [NUM_REGS-1:0] busy_eff
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(g));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       busy_q[g] <= 1'b0;
      else if (hit_set) busy_q[g] <= 1'b1;
      else if (hit_clr) busy_q[g] <= 1'b0;
    end

    // early-half write-back: a clear is visible within the cycle
    assign busy_eff[g] = busy_q[g] & ~hit_clr;
  end

  // R6: a write-back with no competing set leaves the register free
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !busy_q[$past(clr_idx)]);

  // R5: an accepted set is visible from the next edge
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy_q[$past(set_idx)]);

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] busy_eff,
  input  logic [IDX_W-1:0]    src1_idx,
  input  logic                src1_use,
  input  logic [IDX_W-1:0]    src2_idx,
  input  logic                src2_use,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic                dst_wr,
  output logic                raw_hit,
  output logic                waw_hit
);

  always_comb begin
    raw_hit = (src1_use && busy_eff[src1_idx]) ||
              (src2_use && busy_eff[src2_idx]);
    waw_hit = dst_wr && busy_eff[dst_idx];
  end

endmodule

// File: rtl/fp_busy_scoreboard.sv
module fp_busy_scoreboard
  import fp_sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = SB_NUM_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic             src1_use,
  input  logic [IDX_W-1:0] src2_idx,
  input  logic             src2_use,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             dst_wr,
  input  logic             iss_fire,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_idx,
  output logic             stall
);

  logic [NUM_REGS-1:0] busy_q;
  logic [NUM_REGS-1:0] busy_eff;
  logic                raw_hit;
  logic                waw_hit;
  logic                accept_set;

  assign stall      = raw_hit | waw_hit;
  assign accept_set = iss_fire & dst_wr & ~stall;

  sb_busy_table #(.NUM_REGS(NUM_REGS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (accept_set),
    .set_idx  (dst_idx),
    .clr_en   (wb_valid),
    .clr_idx  (wb_idx),
    .busy_q   (busy_q),
    .busy_eff (busy_eff)
  );

  sb_hazard #(.NUM_REGS(NUM_REGS)) u_hazard (
    .busy_eff (busy_eff),
    .src1_idx (src1_idx),
    .src1_use (src1_use),
    .src2_idx (src2_idx),
    .src2_use (src2_use),
    .dst_idx  (dst_idx),
    .dst_wr   (dst_wr),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit)
  );

  // R2: a used source on a pending register holds issue
  p_raw_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_use && busy_q[src1_idx] && !(wb_valid && wb_idx == src1_idx)) |-> stall);

  // R4: a written destination that is still owed a result holds issue
  p_waw_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr && busy_q[dst_idx] && !(wb_valid && wb_idx == dst_idx)) |-> stall);

  // R7: set beats a same-cycle clear on the same register
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && !stall && dst_wr && wb_valid && wb_idx == dst_idx)
      |=> busy_q[$past(dst_idx)]);

  // R8: a fire that is held back marks nothing
  p_held_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && stall && dst_wr && !busy_q[dst_idx]) |=> !busy_q[$past(dst_idx)]);

endmodule

// File: tb/fp_busy_scoreboard_test.sv
module fp_busy_scoreboard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // {s1[5], u1, s2[5], u2, d[5], w, fire, wbv, wbi[5], expected stall}
  localparam logic [25:0] VEC [NV] = '{
    {5'd1,  1'b1, 5'd2, 1'b1, 5'd3,  1'b1, 1'b1, 1'b0, 5'd0, 1'b0}, // R5 issue sets r3
    {5'd3,  1'b1, 5'd0, 1'b0, 5'd4,  1'b1, 1'b1, 1'b0, 5'd0, 1'b1}, // R2 RAW on r3, R8 fire dropped
    {5'd5,  1'b1, 5'd3, 1'b0, 5'd8,  1'b1, 1'b1, 1'b0, 5'd0, 1'b0}, // R3 unused src on r3; sets r8
    {5'd4,  1'b1, 5'd0, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 5'd0, 1'b1}, // R4 WAW on r3; r4 free (R8)
    {5'd3,  1'b1, 5'd0, 1'b0, 5'd6,  1'b1, 1'b1, 1'b1, 5'd3, 1'b0}, // R6 same-cycle clear of r3
    {5'd0,  1'b0, 5'd0, 1'b0, 5'd8,  1'b1, 1'b1, 1'b1, 5'd8, 1'b0}, // R7 set and clear on r8
    {5'd0,  1'b0, 5'd8, 1'b1, 5'd7,  1'b0, 1'b1, 1'b0, 5'd0, 1'b1}, // R7 r8 stays busy
    {5'd0,  1'b0, 5'd8, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 5'd6, 1'b1}, // R2 still r8; clears r6
    {5'd6,  1'b1, 5'd6, 1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R6 r6 free after edge
    {5'd31, 1'b1, 5'd0, 1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0, 1'b0}, // R5 sets r0
    {5'd0,  1'b1, 5'd0, 1'b0, 5'd9,  1'b0, 1'b1, 1'b0, 5'd0, 1'b1}, // R2 RAW on r0
    {5'd1,  1'b1, 5'd0, 1'b0, 5'd10, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}, // R8 fire without write
    {5'd10, 1'b1, 5'd0, 1'b0, 5'd10, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R8 r10 never set
    {5'd0,  1'b0, 5'd8, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b0}  // R3/R4 masks on busy r0,r8
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src1_idx = '0, src2_idx = '0, dst_idx = '0, wb_idx = '0;
  logic       src1_use = 1'b0, src2_use = 1'b0, dst_wr = 1'b0;
  logic       iss_fire = 1'b0, wb_valid = 1'b0;
  logic       stall;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_busy_scoreboard uut (
    .clk(clk), .rst_n(rst_n),
    .src1_idx(src1_idx), .src1_use(src1_use),
    .src2_idx(src2_idx), .src2_use(src2_use),
    .dst_idx(dst_idx), .dst_wr(dst_wr),
    .iss_fire(iss_fire), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .stall(stall)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (stall !== exp) begin
      failures++;
      $display("FAIL %s stall actual=%b expected=%b at %0t", req, stall, exp, $time);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    {src1_idx, src1_use, src2_idx, src2_use, dst_idx, dst_wr,
     iss_fire, wb_valid, wb_idx} = v[25:1];
  endtask

  task automatic idle();
    src1_use = 1'b0; src2_use = 1'b0; dst_wr = 1'b0;
    iss_fire = 1'b0; wb_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: after reset every register is free as source and destination
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      src1_idx = 5'(i); src1_use = 1'b1; dst_idx = 5'(i); dst_wr = 1'b1;
      #2 check("R1", 1'b0);
    end
    @(negedge clk); idle();

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k]);
      #2 check($sformatf("vector %0d", k), VEC[k][0]);
    end

    // R5: fresh issue of r31, then a reader of r31 stalls next cycle
    @(negedge clk); idle();
    dst_idx = 5'd31; dst_wr = 1'b1; iss_fire = 1'b1;
    #2 check("R5", 1'b0);
    @(negedge clk); idle();
    src2_idx = 5'd31; src2_use = 1'b1;
    #2 check("R5", 1'b1);

    // R1: reset mid-run with r0, r8, r31 busy
    @(negedge clk); idle(); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    src1_idx = 5'd0; src1_use = 1'b1; src2_idx = 5'd8; src2_use = 1'b1;
    dst_idx = 5'd31; dst_wr = 1'b1;
    #2 check("R1", 1'b0);

    @(negedge clk); idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule